// File: doc/BRIEF.md
# Split-Option Adaptive Test Word Encoder

This block compresses one block of eight 8-bit test words for download to a tester-side or on-chip decoder. Each word may be coded with a split point B between 0 and 7. The B low bits of the word are sent unchanged, and the remaining high part is sent as a run of that many zeros closed by a single one. One B applies to the whole block. The encoder works out the coded length of the block for all eight split points at once. It keeps the split point that gives the shortest block and sends a 3-bit identifier for it ahead of the coded words.

The block is loaded in parallel with a start pulse. The coded stream leaves one bit per transfer over a valid/ready handshake. The chosen split point and the coded block length (without the identifier) are shown on outputs while the stream is sent. A done strobe marks the transfer of the final bit. A start that arrives while a block is being evaluated or sent has no effect.

Top module: `sdv_split_encoder`

## Requirements
- R1: When the encoder is idle, a high `start_i` at a clock edge captures `words_i`. Word k sits in bits [8k+7:8k] and word 0 is coded first. Later changes on `words_i` do not affect the block in flight.
- R2: The coded length of word w under split point B is B + (w >> B) + 1. `best_total_o` shows the sum of these lengths over the eight words for the chosen B, which is the smallest block sum over B = 0..7.
- R3: `best_b_o` shows the split point with the smallest block sum. When sums are equal, the smaller B is chosen.
- R4: The stream opens with a 3-bit identifier equal to (B + 1) mod 8, sent most significant bit first. B=0..5 give 001..110, B=6 gives 111 and B=7 gives 000.
- R5: After the identifier, the words follow in order 0 to 7. Each word sends its B low bits most significant first, then (w >> B) zeros, then a single one.
- R6: The stream is exactly 3 + `best_total_o` bits long. `done_o` is high only in the cycle where the last bit is transferred (`out_valid_o` and `out_ready_i` both high). After that, `out_valid_o` stays low until the next start.
- R7: While `out_valid_o` is high and `out_ready_i` is low, `out_valid_o` and `out_bit_o` hold their values into the next cycle.
- R8: A start during evaluation or sending is ignored. The stream and both result outputs stay those of the block in flight.
- R9: During reset and after it, before any start, `out_valid_o` and `done_o` are low and `best_b_o` and `best_total_o` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Load request for a new block |
| words_i | input | 64 | Eight packed test words, word k in bits [8k+7:8k] |
| out_ready_i | input | 1 | Downstream accepts a bit this cycle |
| out_valid_o | output | 1 | A coded bit is presented |
| out_bit_o | output | 1 | Current coded bit |
| done_o | output | 1 | Last bit of the block is transferred this cycle |
| best_b_o | output | 3 | Chosen split point |
| best_total_o | output | 12 | Coded block length without the identifier |

## Verification
Several properties are checked on every cycle:
- The reported split point and length are the tie-broken minimum of the eight option sums.
- The number of bits transferred matches 3 plus the reported length when done fires.
- Bits are held under backpressure.
- The results do not move while a block streams.

The exact bit order cannot be seen by those properties: the identifier value, raw fields, run lengths and closing ones. Nor can they show that late starts and changed inputs leave the stream untouched. Only the bench shows these, by comparing each received stream with one built arithmetically. It does this for every uniform block of the 256 word values, for a worked block whose optimum is B=5 at 55 bits, for tie blocks and for pseudo-random blocks, under three ready patterns.

// File: rtl/sdv_pkg.sv
package sdv_pkg;
  localparam int WORD_W    = 8;
  localparam int NUM_WORDS = 8;
  localparam int NUM_OPT   = WORD_W;
  localparam int SEL_W     = $clog2(NUM_OPT);
  localparam int TOT_W     = $clog2(NUM_WORDS * (1 << WORD_W) + 1);

  typedef enum logic [1:0] {ST_IDLE, ST_EVAL, ST_SEND} enc_state_e;
  typedef enum logic [1:0] {PH_ID, PH_RAW, PH_ZERO, PH_TERM} ser_phase_e;
endpackage

// File: rtl/sdv_optlen.sv
// Coded length of the whole block for one fixed split point.
module sdv_optlen #(
  parameter int WORD_W    = 8,
  parameter int NUM_WORDS = 8,
  parameter int SPLIT     = 0,
  parameter int TOT_W     = 12
) (
  input  logic [NUM_WORDS*WORD_W-1:0] words_i,
  output logic [TOT_W-1:0]            total_o
);
  always_comb begin
    total_o = '0;
    for (int k = 0; k < NUM_WORDS; k++) begin
      total_o = total_o + TOT_W'(SPLIT)
              + TOT_W'(words_i[k*WORD_W +: WORD_W] >> SPLIT) + TOT_W'(1);
    end
  end
endmodule

// File: rtl/sdv_argmin.sv
// Smallest option sum; strict compare keeps the lower index on ties.
module sdv_argmin #(
  parameter int NUM_OPT = 8,
  parameter int TOT_W   = 12,
  parameter int SEL_W   = 3
) (
  input  logic [NUM_OPT-1:0][TOT_W-1:0] totals_i,
  output logic [SEL_W-1:0]              sel_o,
  output logic [TOT_W-1:0]              min_o
);
  always_comb begin
    sel_o = '0;
    min_o = totals_i[0];
    for (int i = 1; i < NUM_OPT; i++) begin
      if (totals_i[i] < min_o) begin
        min_o = totals_i[i];
        sel_o = SEL_W'(i);
      end
    end
  end
endmodule

// File: rtl/sdv_serializer.sv
// Emits identifier, then per word: raw low field, zero run, closing one.
module sdv_serializer
  import sdv_pkg::*;
#(
  parameter int WORD_W    = 8,
  parameter int NUM_WORDS = 8,
  parameter int SEL_W     = 3,
  localparam int IDX_W    = $clog2(NUM_WORDS),
  localparam int CNT_W    = WORD_W
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        load_i,
  input  logic [SEL_W-1:0]            split_i,
  input  logic [NUM_WORDS*WORD_W-1:0] words_i,
  input  logic                        ready_i,
  output logic                        valid_o,
  output logic                        bit_o,
  output logic                        last_o
);
  ser_phase_e       phase_q, phase_d, ent_phase;
  logic             active_q, active_d;
  logic [CNT_W-1:0] cnt_q, cnt_d, ent_cnt;
  logic [IDX_W-1:0] idx_q, idx_d, ent_idx;
  logic [WORD_W-1:0] cur_word, ent_word, cur_run, ent_run;
  logic [SEL_W-1:0] id_code;
  logic             fire;

  assign cur_word = words_i[idx_q*WORD_W +: WORD_W];
  assign cur_run  = cur_word >> split_i;
  assign ent_idx  = (phase_q == PH_ID) ? '0 : idx_q + 1'b1;
  assign ent_word = words_i[ent_idx*WORD_W +: WORD_W];
  assign ent_run  = ent_word >> split_i;
  assign id_code  = split_i + 1'b1;
  assign fire     = active_q & ready_i;
  assign valid_o  = active_q;
  assign last_o   = active_q && (phase_q == PH_TERM) &&
                    (idx_q == IDX_W'(NUM_WORDS - 1));

  always_comb begin
    unique case (phase_q)
      PH_ID:   bit_o = id_code[cnt_q[SEL_W-1:0]];
      PH_RAW:  bit_o = cur_word[cnt_q[SEL_W-1:0]];
      PH_ZERO: bit_o = 1'b0;
      default: bit_o = 1'b1;
    endcase
  end

  // Entry point of the next word to be coded.
  always_comb begin
    if (split_i != '0) begin
      ent_phase = PH_RAW;
      ent_cnt   = CNT_W'(split_i) - 1'b1;
    end else if (ent_run != '0) begin
      ent_phase = PH_ZERO;
      ent_cnt   = ent_run - 1'b1;
    end else begin
      ent_phase = PH_TERM;
      ent_cnt   = '0;
    end
  end

  always_comb begin
    active_d = active_q;
    phase_d  = phase_q;
    cnt_d    = cnt_q;
    idx_d    = idx_q;
    if (load_i) begin
      active_d = 1'b1;
      phase_d  = PH_ID;
      cnt_d    = CNT_W'(SEL_W - 1);
      idx_d    = '0;
    end else if (fire) begin
      unique case (phase_q)
        PH_ID: begin
          if (cnt_q == '0) begin
            phase_d = ent_phase;
            cnt_d   = ent_cnt;
            idx_d   = ent_idx;
          end else begin
            cnt_d = cnt_q - 1'b1;
          end
        end
        PH_RAW: begin
          if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
          end else if (cur_run != '0) begin
            phase_d = PH_ZERO;
            cnt_d   = cur_run - 1'b1;
          end else begin
            phase_d = PH_TERM;
          end
        end
        PH_ZERO: begin
          if (cnt_q == '0) phase_d = PH_TERM;
          else             cnt_d   = cnt_q - 1'b1;
        end
        default: begin
          if (last_o) begin
            active_d = 1'b0;
          end else begin
            phase_d = ent_phase;
            cnt_d   = ent_cnt;
            idx_d   = ent_idx;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      phase_q  <= PH_ID;
      cnt_q    <= '0;
      idx_q    <= '0;
    end else begin
      active_q <= active_d;
      phase_q  <= phase_d;
      cnt_q    <= cnt_d;
      idx_q    <= idx_d;
    end
  end
endmodule

// File: rtl/sdv_split_encoder.sv
module sdv_split_encoder
  import sdv_pkg::*;
#(
  parameter int WORD_W    = sdv_pkg::WORD_W,
  parameter int NUM_WORDS = sdv_pkg::NUM_WORDS,
  localparam int NUM_OPT  = WORD_W,
  localparam int SEL_W    = $clog2(NUM_OPT),
  localparam int TOT_W    = $clog2(NUM_WORDS * (1 << WORD_W) + 1),
  localparam int BLK_W    = NUM_WORDS * WORD_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [BLK_W-1:0] words_i,
  input  logic             out_ready_i,
  output logic             out_valid_o,
  output logic             out_bit_o,
  output logic             done_o,
  output logic [SEL_W-1:0] best_b_o,
  output logic [TOT_W-1:0] best_total_o
);
  logic rst_meta_q, rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  enc_state_e state_q, state_d;
  logic [BLK_W-1:0] words_q;
  logic [SEL_W-1:0] best_b_q, sel_b;
  logic [TOT_W-1:0] best_total_q, sel_total;
  logic [NUM_OPT-1:0][TOT_W-1:0] tot_all;
  logic load_en, latch_en, ser_last;

  for (genvar g = 0; g < NUM_OPT; g++) begin : g_opt
    sdv_optlen #(
      .WORD_W(WORD_W), .NUM_WORDS(NUM_WORDS), .SPLIT(g), .TOT_W(TOT_W)
    ) u_len (
      .words_i(words_q),
      .total_o(tot_all[g])
    );
  end

  sdv_argmin #(.NUM_OPT(NUM_OPT), .TOT_W(TOT_W), .SEL_W(SEL_W)) u_min (
    .totals_i(tot_all),
    .sel_o   (sel_b),
    .min_o   (sel_total)
  );

  sdv_serializer #(.WORD_W(WORD_W), .NUM_WORDS(NUM_WORDS), .SEL_W(SEL_W)) u_ser (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .load_i (latch_en),
    .split_i(best_b_q),
    .words_i(words_q),
    .ready_i(out_ready_i),
    .valid_o(out_valid_o),
    .bit_o  (out_bit_o),
    .last_o (ser_last)
  );

  assign load_en  = (state_q == ST_IDLE) && start_i;
  assign latch_en = (state_q == ST_EVAL);
  assign done_o   = ser_last && out_ready_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (start_i) state_d = ST_EVAL;
      ST_EVAL: state_d = ST_SEND;
      default: if (done_o) state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      state_q      <= ST_IDLE;
      best_b_q     <= '0;
      best_total_q <= '0;
    end else begin
      state_q <= state_d;
      if (latch_en) begin
        best_b_q     <= sel_b;
        best_total_q <= sel_total;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (load_en) words_q <= words_i;
  end

  assign best_b_o     = best_b_q;
  assign best_total_o = best_total_q;
endmodule

// File: rtl/sdv_split_encoder_chk.sv
module sdv_split_encoder_chk #(
  parameter int NUM_OPT = sdv_pkg::NUM_OPT,
  parameter int SEL_W   = sdv_pkg::SEL_W,
  parameter int TOT_W   = sdv_pkg::TOT_W
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        out_ready_i,
  input logic                        out_valid_o,
  input logic                        out_bit_o,
  input logic                        done_o,
  input logic [SEL_W-1:0]            best_b_o,
  input logic [TOT_W-1:0]            best_total_o,
  input logic [NUM_OPT-1:0][TOT_W-1:0] tot_all
);
  logic [TOT_W:0] bit_cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                           bit_cnt_q <= '0;
    else if (out_valid_o && out_ready_i)  bit_cnt_q <= done_o ? '0 : bit_cnt_q + 1'b1;
  end

  function automatic logic pick_ok(input logic [NUM_OPT-1:0][TOT_W-1:0] t,
                                   input logic [SEL_W-1:0] b,
                                   input logic [TOT_W-1:0] m);
    logic ok;
    ok = (t[b] == m);
    for (int i = 0; i < NUM_OPT; i++) begin
      if (t[i] < m) ok = 1'b0;
      if ((i < int'(b)) && (t[i] == m)) ok = 1'b0;
    end
    return ok;
  endfunction

  // R2 and R3: reported result is the tie-broken minimum of the option sums
  assert_pick_R3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid_o |-> pick_ok(tot_all, best_b_o, best_total_o));

  assert_len_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (bit_cnt_q == (TOT_W+1)'(best_total_o) + (TOT_W+1)'(SEL_W - 1)));

  assert_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (out_valid_o && out_ready_i));

  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(out_bit_o)));

  assert_keep_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid_o && !done_o) |=> (out_valid_o && $stable(best_b_o) && $stable(best_total_o)));
endmodule

bind sdv_split_encoder sdv_split_encoder_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .out_ready_i (out_ready_i),
  .out_valid_o (out_valid_o),
  .out_bit_o   (out_bit_o),
  .done_o      (done_o),
  .best_b_o    (best_b_o),
  .best_total_o(best_total_o),
  .tot_all     (tot_all)
);

// File: tb/sdv_split_encoder_bench.sv
module sdv_split_encoder_bench;
  localparam int CLK_PERIOD = 10;
  localparam int MAXB = 2100;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start;
  logic [63:0] words;
  logic        ready;
  logic        out_valid, out_bit, done;
  logic [2:0]  best_b;
  logic [11:0] best_total;

  int n_chk = 0;
  int n_fail = 0;

  bit exp_bits [MAXB];
  bit got_bits [MAXB];
  int exp_n, exp_b, exp_tot;

  always #(CLK_PERIOD/2) clk = ~clk;

  sdv_split_encoder u_sdv_split_encoder (
    .clk(clk), .rst_n(rst_n), .start_i(start), .words_i(words),
    .out_ready_i(ready), .out_valid_o(out_valid), .out_bit_o(out_bit),
    .done_o(done), .best_b_o(best_b), .best_total_o(best_total)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int olen(input logic [7:0] w, input int b);
    return b + int'(w >> b) + 1;
  endfunction

  task automatic push(input bit v);
    if (exp_n < MAXB) exp_bits[exp_n] = v;
    exp_n++;
  endtask

  task automatic build_expected(input logic [63:0] blk);
    int tot;
    int id;
    logic [7:0] w;
    exp_b = 0;
    exp_tot = 1 << 30;
    for (int b = 0; b < 8; b++) begin
      tot = 0;
      for (int k = 0; k < 8; k++) tot += olen(blk[k*8 +: 8], b);
      if (tot < exp_tot) begin exp_tot = tot; exp_b = b; end
    end
    exp_n = 0;
    id = (exp_b + 1) % 8;
    for (int i = 2; i >= 0; i--) push(id[i]);
    for (int k = 0; k < 8; k++) begin
      w = blk[k*8 +: 8];
      for (int i = exp_b - 1; i >= 0; i--) push(w[i]);
      for (int z = 0; z < int'(w >> exp_b); z++) push(1'b0);
      push(1'b1);
    end
  endtask

  function automatic bit ready_pat(input int mode, input int cyc);
    case (mode)
      0: return 1'b1;
      1: return (cyc % 3) != 0;
      default: return ((cyc * 7) % 5) < 3;
    endcase
  endfunction

  task automatic run_block(input logic [63:0] blk, input bit disturb, input int rmode);
    int n, cyc, first_bad;
    bit got_done, hold_bad, bad_done, prev_stall, prev_bit, stalled;
    build_expected(blk);
    @(negedge clk);
    start = 1'b1; words = blk; ready = 1'b0;
    @(negedge clk);
    start = 1'b0; words = ~blk;   // R1: later input changes must not matter
    n = 0; cyc = 0; got_done = 0; hold_bad = 0; bad_done = 0;
    prev_stall = 0; prev_bit = 0; stalled = 0;
    while (!got_done && cyc < 6000) begin
      @(negedge clk);
      cyc++;
      ready = ready_pat(rmode, cyc);
      if (disturb && cyc == 4) begin start = 1'b1; words = blk ^ 64'h0123_4567_89ab_cdef; end
      else start = 1'b0;
      #1;
      if (prev_stall && (!out_valid || out_bit != prev_bit)) hold_bad = 1;
      prev_stall = out_valid && !ready;
      if (prev_stall) stalled = 1;
      prev_bit = out_bit;
      if (done && !(out_valid && ready)) bad_done = 1;
      if (out_valid && ready) begin
        if (n < MAXB) got_bits[n] = out_bit;
        n++;
        if (done) got_done = 1;
      end
    end
    start = 1'b0;
    check(best_b == 3'(exp_b), "R3", "chosen split", best_b, exp_b);
    check(best_total == 12'(exp_tot), "R2", "block length", best_total, exp_tot);
    check({got_bits[0], got_bits[1], got_bits[2]} == 3'((exp_b + 1) % 8), "R4", "identifier",
          {got_bits[0], got_bits[1], got_bits[2]}, (exp_b + 1) % 8);
    first_bad = -1;
    for (int i = 0; i < exp_n && i < n; i++)
      if (first_bad < 0 && got_bits[i] != exp_bits[i]) first_bad = i;
    check(first_bad < 0, "R1 R5", "first mismatching bit index", first_bad, -1);
    check(got_done && n == exp_n && !bad_done, "R6", "bits until done", n, exp_n);
    if (stalled) check(!hold_bad, "R7", "hold under stall", hold_bad, 0);
    if (disturb) check(first_bad < 0 && best_b == 3'(exp_b), "R8", "busy start ignored",
                       best_b, exp_b);
    @(negedge clk); #1;
    check(!out_valid && !done, "R6", "idle after done", out_valid, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [63:0] lf;
    logic [63:0] doc_blk;
    rst_n = 1'b0; start = 1'b0; words = '0; ready = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    check(!out_valid && !done && best_b == 0 && best_total == 0, "R9", "in reset",
          {out_valid, done, best_b, best_total}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    check(!out_valid && !done && best_b == 0 && best_total == 0, "R9", "after reset",
          {out_valid, done, best_b, best_total}, 0);

    // R3 worked block: optimum B=5 with 55 bits
    doc_blk = {8'b00001010, 8'b00110100, 8'b01100100, 8'b00001111,
               8'b00111100, 8'b01011010, 8'b00011111, 8'b00001111};
    run_block(doc_blk, 1'b0, 0);
    check(best_b == 3'd5 && best_total == 12'd55, "R3", "worked block", best_total, 55);
    // R4 identifiers at the ends: all-zero B=0 (001), all-ones B=7 (000), 127s B=6 (111)
    run_block(64'h0, 1'b0, 1);
    check(best_b == 3'd0 && best_total == 12'd8, "R4", "zero block total", best_total, 8);
    run_block({8{8'hFF}}, 1'b0, 2);
    check(best_b == 3'd7 && best_total == 12'd72, "R4", "ones block total", best_total, 72);
    run_block({8{8'h7F}}, 1'b0, 0);
    check(best_b == 3'd6 && best_total == 12'd64, "R3", "tie 6/7 to 6", best_b, 6);
    // R3 three-way tie B=0,1,2 at 24 bits
    run_block({8{8'h02}}, 1'b1, 1);
    check(best_b == 3'd0 && best_total == 12'd24, "R3", "tie 0/1/2 to 0", best_b, 0);

    for (int v = 0; v < 256; v++) run_block({8{8'(v)}}, (v % 16) == 5, v % 3);

    lf = 64'h9E37_79B9_7F4A_7C15;
    for (int r = 0; r < 60; r++) begin
      lf ^= lf << 13; lf ^= lf >> 7; lf ^= lf << 17;
      run_block(lf, (r % 7) == 3, r % 3);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule